// File: doc/BRIEF.md
# Serial-Addressed Octal DAC Code Register Bank

This block is the digital front end of an eight-channel, 14-bit converter array. A host writes one channel at a time over a three-wire serial link: a serial clock, a serial data line and a load strobe. Each write is an 18-bit frame. It carries a 4-bit channel address followed by a 14-bit code. When the load strobe drops, the address is decoded and one of eight 14-bit code registers takes the data. The eight codes are driven in parallel to the converters. The codes are offset binary: 0x0000 is negative full scale, 0x2000 is zero volts, and 0x3FFF is one step below positive full scale.

The serial output carries the bit that leaves the shift register. It can feed the next device in a chain, or it can return the frame that was just written. The pin is modelled as a data bit and an output enable. An active-low asynchronous preset returns every channel to the zero-volt code and clears the shifter.

The three serial inputs are brought into the system clock domain through a two-stage synchroniser. A three-state controller then acts on them:
- FROZEN: the strobe is low. Shifting stops and the output is disabled.
- SHIFT: the strobe is high. Shifting runs and the output is driven.
- COMMIT: a one-cycle write of the selected channel.

The controller moves between states as follows:
- FROZEN→SHIFT when the synchronised strobe is high.
- SHIFT→COMMIT when the synchronised strobe is seen low.
- COMMIT→FROZEN always.

Top module: `octal_code_bank`

## Requirements
- R1: A frame is 18 bits sent most significant bit first. The first 4 bits are the address (bit 3 first), and the last 14 bits are the code (bit 13 first). Each rising edge of `ser_clk` seen while `ser_load` is high shifts `ser_din` into the frame.
- R2: When `ser_load` falls, the code field of the frame is written to channel `addr`, for addresses 0 to 7. Channel n occupies `chan_codes[14n+13:14n]`.
- R3: An address of 8 to 15 (address bit 3 set) writes no channel. All eight codes keep their values.
- R4: While `ser_load` is low, `ser_clk` and `ser_din` have no effect on the shift register. The frame held at the strobe's fall is still present when the strobe returns high.
- R5: `ser_dout_en` is low while `ser_load` is low. It is high while `ser_load` is high and shifting is active.
- R6: `ser_dout` is the frame's most significant bit. After the 18th shift it shows address bit 3, and each later shift presents the next frame bit, so the whole frame reads back in order.
- R7: `preset_n` low sets all eight codes to 0x2000 at once, without waiting for a clock, and clears the shift register to all zeros.
- R8: After the preset is released, every code holds until a valid commit occurs.
- R9: A `ser_clk` rising edge that arrives together with the fall of `ser_load` is not counted as a shift. The frame committed is the one before that edge.
- R10: Inputs pass through two synchroniser stages. A commit takes effect on the fourth system clock edge after the fall of `ser_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| preset_n | input | 1 | Asynchronous active-low preset to the zero-volt code |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | High: shift; falling edge: commit; low: frozen |
| ser_dout | output | 1 | Bit leaving the shift register |
| ser_dout_en | output | 1 | Drive enable for `ser_dout` (low means high impedance) |
| chan_codes | output | 112 | Eight 14-bit channel codes, channel 0 in the low bits |

## Verification
The commit and the shift can fall in the same cycle: a serial clock rising edge can arrive with the strobe's fall. The bench provokes this by raising `ser_clk` with a different `ser_din` value at the same instant it drops `ser_load`. The test passes when the target channel holds the unshifted code and the address still selects that channel. The asynchronous preset is also applied in the middle of a frame, which checks that it overrides both shifting and commit.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;
    typedef enum logic [1:0] {
        ST_FROZEN = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } sdac_state_e;
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pipe[s] <= '0;
            else if (s == 0)
                pipe[s] <= d;
            else
                pipe[s] <= pipe[(s == 0) ? 0 : s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdac_ctrl.sv
`timescale 1ns/1ps
module sdac_ctrl
    import sdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_s,
    input  logic        sclk_s,
    output sdac_state_e state,
    output logic        shift_en,
    output logic        commit_en,
    output logic        dout_en
);
    sdac_state_e state_nx;
    logic        sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_FROZEN;
            sclk_prev <= 1'b0;
        end else begin
            state     <= state_nx;
            sclk_prev <= sclk_s;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FROZEN: if (load_s)  state_nx = ST_SHIFT;
            ST_SHIFT:  if (!load_s) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_FROZEN;
            default:   state_nx = ST_FROZEN;
        endcase
    end

    always_comb begin
        shift_en  = (state == ST_SHIFT) && load_s && sclk_s && !sclk_prev;
        commit_en = (state == ST_COMMIT);
        dout_en   = (state == ST_SHIFT);
    end
endmodule

// File: rtl/sdac_shifter.sv
`timescale 1ns/1ps
module sdac_shifter #(
    parameter int FW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          din,
    output logic [FW-1:0] frame,
    output logic          dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            frame <= '0;
        else if (shift_en)
            frame <= {frame[FW-2:0], din};
    end

    assign dout = frame[FW-1];
endmodule

// File: rtl/sdac_regfile.sv
`timescale 1ns/1ps
module sdac_regfile #(
    parameter int NCH = 8,
    parameter int CW  = 14,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     data,
    output logic [NCH*CW-1:0] codes
);
    localparam logic [CW-1:0] MID_CODE = CW'(1) << (CW-1);

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic [CW-1:0] code_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                code_q <= MID_CODE;
            else if (commit_en && (addr == AW'(i)))
                code_q <= data;
        end
        assign codes[i*CW +: CW] = code_q;
    end
endmodule

// File: rtl/octal_code_bank.sv
`timescale 1ns/1ps
module octal_code_bank
    import sdac_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int CODE_W      = 14,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  preset_n,
    input  logic                  ser_clk,
    input  logic                  ser_din,
    input  logic                  ser_load,
    output logic                  ser_dout,
    output logic                  ser_dout_en,
    output logic [NCH*CODE_W-1:0] chan_codes
);
    localparam int FRAME_W = ADDR_W + CODE_W;

    logic [2:0]         sync_q;
    logic               load_s, sclk_s, din_s;
    sdac_state_e        state;
    logic               shift_en, commit_en;
    logic [FRAME_W-1:0] frame;

    sdac_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (preset_n),
        .d     ({ser_load, ser_clk, ser_din}),
        .q     (sync_q)
    );
    assign {load_s, sclk_s, din_s} = sync_q;

    sdac_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (preset_n),
        .load_s    (load_s),
        .sclk_s    (sclk_s),
        .state     (state),
        .shift_en  (shift_en),
        .commit_en (commit_en),
        .dout_en   (ser_dout_en)
    );

    sdac_shifter #(.FW(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (preset_n),
        .shift_en (shift_en),
        .din      (din_s),
        .frame    (frame),
        .dout     (ser_dout)
    );

    sdac_regfile #(.NCH(NCH), .CW(CODE_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (preset_n),
        .commit_en (commit_en),
        .addr      (frame[FRAME_W-1 -: ADDR_W]),
        .data      (frame[CODE_W-1:0]),
        .codes     (chan_codes)
    );
endmodule

// File: rtl/sdac_checker.sv
`timescale 1ns/1ps
module sdac_checker
    import sdac_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 14,
    parameter int AW  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ld_s,
    input sdac_state_e           st,
    input logic                  commit,
    input logic [AW+CW-1:0]      frame,
    input logic [NCH*CW-1:0]     codes,
    input logic                  dout_en
);
    localparam int FW = AW + CW;
    logic [AW-1:0] f_addr;
    assign f_addr = frame[FW-1 -: AW];

    // R4: frozen shifter keeps its contents
    a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FROZEN) |=> $stable(frame));

    // R9: the cycle the strobe is seen low admits no shift
    a_r9_no_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && !ld_s) |=> $stable(frame));

    // R5: output disabled once the strobe has been low two cycles
    a_r5_dout_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_s && !$past(ld_s)) |-> !dout_en);

    // R3: out-of-range address leaves every code alone
    a_r3_nop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (int'(f_addr) >= NCH)) |=> $stable(codes));

    // R8: codes move only on a commit
    a_r8_hold_codes: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(codes));

    // R2: commit writes the selected channel
    for (genvar i = 0; i < NCH; i++) begin : g_wr
        a_r2_write_chan: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && f_addr == AW'(i)) |=> (codes[i*CW +: CW] == $past(frame[CW-1:0])));
    end
endmodule

bind octal_code_bank sdac_checker #(.NCH(NCH), .CW(CODE_W), .AW(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (preset_n),
    .ld_s    (load_s),
    .st      (state),
    .commit  (commit_en),
    .frame   (frame),
    .codes   (chan_codes),
    .dout_en (ser_dout_en)
);

// File: tb/octal_code_bank_tb.sv
`timescale 1ns/1ps
module octal_code_bank_tb;
    localparam int NCH = 8;
    localparam int CW  = 14;

    logic clk = 1'b0;
    logic preset_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_load = 1'b0;
    logic ser_dout, ser_dout_en;
    logic [NCH*CW-1:0] chan_codes;

    int checks = 0;
    int fails  = 0;
    logic [CW-1:0] model [NCH];

    always #10 clk = ~clk;

    octal_code_bank u_dut (
        .clk         (clk),
        .preset_n    (preset_n),
        .ser_clk     (ser_clk),
        .ser_din     (ser_din),
        .ser_load    (ser_load),
        .ser_dout    (ser_dout),
        .ser_dout_en (ser_dout_en),
        .chan_codes  (chan_codes)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < NCH; c++)
            chk(req, 32'(chan_codes[c*CW +: CW]), 32'(model[c]));
    endtask

    task automatic pulse_bit(input logic b);
        ser_din = b; tick(3);
        ser_clk = 1'b1; tick(3);
        ser_clk = 1'b0; tick(3);
    endtask

    task automatic send_frame(input logic [17:0] f);
        ser_load = 1'b1; tick(4);
        for (int i = 17; i >= 0; i--) pulse_bit(f[i]);
    endtask

    task automatic commit_frame;
        ser_load = 1'b0; tick(6);
    endtask

    // R1 R2 R10: write a channel
    task automatic t_write(input logic [3:0] a, input logic [13:0] d);
        send_frame({a, d});
        ser_load = 1'b0;
        tick(3);
        chk("R10 not yet committed", 32'(chan_codes[a[2:0]*CW +: CW]), 32'(model[a[2:0]]));
        tick(3);
        if (!a[3]) model[a[2:0]] = d;
        chk_all("R1/R2 frame write");
    endtask

    task automatic t_all_channels;
        for (int c = 0; c < NCH; c++)
            t_write(4'(c), 14'((c * 14'h0931) ^ 14'h1555));
        t_write(4'd0, 14'h0000);
        t_write(4'd7, 14'h3FFF);
        chk_all("R2 all channels");
    endtask

    // R3: nop addresses
    task automatic t_nop;
        t_write(4'd8, 14'h0ABC);
        chk_all("R3 addr 8 nop");
        t_write(4'd15, 14'h3333);
        chk_all("R3 addr 15 nop");
    endtask

    // R4 R5 R6: frozen inputs, hi-Z, readback
    task automatic t_freeze_readback;
        logic [17:0] f = {4'd2, 14'h2C5A};
        send_frame(f);
        chk("R5 dout enabled while load high", 32'(ser_dout_en), 1);
        chk("R6 first bit after 18 shifts", 32'(ser_dout), 32'(f[17]));
        commit_frame();
        model[2] = 14'h2C5A;
        chk_all("R2 readback frame write");
        chk("R5 dout disabled while load low", 32'(ser_dout_en), 0);
        for (int k = 0; k < 5; k++) pulse_bit(1'b1);
        chk("R5 still disabled", 32'(ser_dout_en), 0);
        chk_all("R4 toggles while low change nothing");
        ser_load = 1'b1; tick(4);
        for (int i = 17; i >= 0; i--) begin
            chk("R4/R6 readback bit", 32'(ser_dout), 32'(f[i]));
            pulse_bit(1'b1);
        end
        commit_frame();
        chk_all("R3 all-ones frame is nop");
    endtask

    // R9: clock edge together with load fall
    task automatic t_coincident;
        send_frame({4'd5, 14'h1234});
        ser_din = 1'b1; tick(3);
        ser_clk = 1'b1;
        ser_load = 1'b0;
        tick(6);
        ser_clk = 1'b0;
        tick(3);
        model[5] = 14'h1234;
        chk_all("R9 coincident edge not shifted");
    endtask

    // R7 R8: asynchronous preset mid-frame
    task automatic t_preset;
        ser_load = 1'b1; tick(4);
        for (int k = 0; k < 7; k++) pulse_bit(1'b1);
        #3 preset_n = 1'b0;
        #2;
        for (int c = 0; c < NCH; c++) model[c] = 14'h2000;
        chk_all("R7 async preset");
        ser_load = 1'b0;
        tick(2);
        preset_n = 1'b1;
        tick(8);
        chk_all("R8 hold after preset");
        chk("R5 disabled after preset", 32'(ser_dout_en), 0);
        ser_load = 1'b1; tick(4);
        for (int i = 0; i < 18; i++) begin
            chk("R7 shifter cleared", 32'(ser_dout), 0);
            pulse_bit(1'b1);
        end
        commit_frame();
        chk_all("R8 nop after preset");
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) model[c] = 14'h2000;
        tick(3);
        chk_all("R7 reset codes 0x2000");
        chk("R5 reset dout disabled", 32'(ser_dout_en), 0);
        preset_n = 1'b1;
        tick(4);
        t_all_channels();
        t_nop();
        t_freeze_readback();
        t_coincident();
        t_preset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule